// File: doc/BRIEF.md
# Probe Access Permission Checker

This block answers one question about a data address: would a read, a write, or a read-and-write at a given privilege level be allowed? It holds a small fully associative data TLB that is loaded through a fill port. Each probe carries an address, a privilege taken either from the low bits of a register operand or from a 2-bit immediate, an access kind, and a form bit. The result form returns 1 or 0. The fault form stays silent when access is allowed and reports a fault code otherwise.

The outcome depends on three control inputs: the data-translation enable, the protection-key enable and the interruption-collection bit. With translation on, a TLB miss cannot be resolved here. It is handed out as a one-cycle walk request that carries the probed address. With translation off, the result form still searches the TLB and faults on a miss. The fault form instead treats the address as physical and only checks whether it is implemented. Each accepted request produces exactly one event one cycle later: either a response pulse or a walk request pulse.

Top module: `probe_check`

## Requirements
- R1: `req_ready` is 1 from the first clock after reset. Each request accepted at an edge gives exactly one of `rsp_valid` or `walk_req` high for the next cycle. Neither is high in any cycle that does not follow an accepted request.
- R2: In the result form (`req_fault_form`=0), a TLB hit gives `rsp_result`=1 when the access is permitted and 0 when it is denied, with `rsp_fault`=0.
- R3: In the fault form (`req_fault_form`=1), `rsp_result` is always 0. A permitted hit gives `rsp_fault`=0. A denied hit gives fault 4 when the privilege or rights check fails, and fault 5 when only the key check fails.
- R4: Address bits 63:61 select one of eight region identifiers from `rr_rids` (region r in bits r*RID_W +: RID_W). An entry hits only when that identifier and the page number in bits VA_BITS-1:PAGE_BITS both match a valid entry.
- R5: The privilege under test is `req_imm` when `req_use_imm`=1, and `req_reg_lo` otherwise.
- R6: `req_kind` is coded 01 read, 10 write, 11 read-and-write, with 00 treated as read. Rights code bit 0 grants read, bit 1 grants write, and bit 2 denies write. Each requested direction also needs the request privilege to be numerically at least the entry privilege.
- R7: When `ctl_pk`=1, an access is also denied if the entry key differs from `key_cur`, if a read is requested while `key_no_rd`=1, or if a write is requested while `key_no_wr`=1. When `ctl_pk`=0 the key plays no part.
- R8: With `ctl_dt`=1, a TLB miss on an implemented address raises `walk_req` and sets `walk_addr` to the probed address, in both forms.
- R9: With `ctl_dt`=0, a result-form miss gives fault 2 when `ctl_ic`=1 and fault 3 when `ctl_ic`=0.
- R10: With `ctl_dt`=0, a fault-form probe on an implemented physical address gives no fault and `rsp_result`=0, whatever the TLB holds.
- R11: An address is an unimplemented virtual address if any of bits 60:VA_BITS is set, and an unimplemented physical address if any of bits 63:PA_BITS is set. The result form returns 0 with no fault for an unimplemented virtual address. The fault form gives fault 1: it tests the virtual address when `ctl_dt`=1 and the physical address when `ctl_dt`=0.
- R12: `rsp_synd` is {non-access, write, read}. On any fault it is 1 followed by the write and read request flags of R6. With no fault it is 000.
- R13: A fill with `fill_en`=1 writes entry `fill_idx` at the clock edge. The new contents take effect on the next probe, and `fill_valid`=0 removes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Probe request valid |
| req_ready | output | 1 | Request accepted when high |
| req_addr | input | 64 | Probed address |
| req_reg_lo | input | 2 | Bits 1:0 of the register operand |
| req_imm | input | 2 | Immediate privilege |
| req_use_imm | input | 1 | Select immediate privilege |
| req_kind | input | 2 | Access kind |
| req_fault_form | input | 1 | 1 fault form, 0 result form |
| ctl_dt | input | 1 | Data translation enable |
| ctl_pk | input | 1 | Protection-key check enable |
| ctl_ic | input | 1 | Interruption collection |
| rr_rids | input | 8*RID_W | Eight region identifiers |
| key_cur | input | KEY_W | Key the entry must match |
| key_no_rd | input | 1 | Key disables read |
| key_no_wr | input | 1 | Key disables write |
| fill_en | input | 1 | TLB write strobe |
| fill_idx | input | IDX_W | Entry to write |
| fill_valid | input | 1 | Valid bit to write |
| fill_rid | input | RID_W | Region identifier to write |
| fill_vpn | input | VPN_W | Page number to write |
| fill_pl | input | 2 | Entry privilege |
| fill_ar | input | 3 | Entry rights code |
| fill_key | input | KEY_W | Entry key |
| rsp_valid | output | 1 | Response pulse |
| rsp_result | output | 1 | Result-form answer |
| rsp_fault | output | 3 | Fault code: 0 none, 1 unimplemented, 2 alternate miss, 3 nested miss, 4 rights, 5 key |
| rsp_synd | output | 3 | Syndrome {non-access, write, read} |
| walk_req | output | 1 | Walk request pulse |
| walk_addr | output | 64 | Address for the walker |

## Verification
The bench sweeps every combination of entry privilege, rights code, request privilege, access kind, form and privilege source. This catches an inverted privilege comparison, a write-deny bit that is ignored, or the immediate and register sources being swapped. A key sweep checks that a key mismatch turns into fault 5 and not fault 4, and that read and write disables act only on their own direction. The translation-off cases check that the interruption bit picks between faults 2 and 3. They also check that the fault form skips the TLB, so a design that still searches it would fault on a miss. Unimplemented addresses are probed in both forms to expose a design that tests the wrong bit range for the current translation mode. Probes to a matching page under the wrong region, and after an entry is invalidated, must produce walk requests and not stale hits.

// File: rtl/probe_check.sv
module probe_check #(
  parameter int VA_BITS   = 50,
  parameter int PA_BITS   = 48,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 4,
  parameter int RID_W     = 8,
  parameter int KEY_W     = 4,
  localparam int VPN_W    = VA_BITS - PAGE_BITS,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [63:0]        req_addr,
  input  logic [1:0]         req_reg_lo,
  input  logic [1:0]         req_imm,
  input  logic               req_use_imm,
  input  logic [1:0]         req_kind,
  input  logic               req_fault_form,
  input  logic               ctl_dt,
  input  logic               ctl_pk,
  input  logic               ctl_ic,
  input  logic [8*RID_W-1:0] rr_rids,
  input  logic [KEY_W-1:0]   key_cur,
  input  logic               key_no_rd,
  input  logic               key_no_wr,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic               fill_valid,
  input  logic [RID_W-1:0]   fill_rid,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [1:0]         fill_pl,
  input  logic [2:0]         fill_ar,
  input  logic [KEY_W-1:0]   fill_key,
  output logic               rsp_valid,
  output logic               rsp_result,
  output logic [2:0]         rsp_fault,
  output logic [2:0]         rsp_synd,
  output logic               walk_req,
  output logic [63:0]        walk_addr
);

  localparam logic [2:0] F_NONE   = 3'd0;
  localparam logic [2:0] F_UNIMPL = 3'd1;
  localparam logic [2:0] F_ALT    = 3'd2;
  localparam logic [2:0] F_NEST   = 3'd3;
  localparam logic [2:0] F_RIGHTS = 3'd4;
  localparam logic [2:0] F_KEY    = 3'd5;

  logic [ENTRIES-1:0] e_v;
  logic [RID_W-1:0]   e_rid [ENTRIES];
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [1:0]         e_pl  [ENTRIES];
  logic [2:0]         e_ar  [ENTRIES];
  logic [KEY_W-1:0]   e_key [ENTRIES];
  logic [ENTRIES-1:0] match;

  wire accept = req_valid && req_ready;
  wire [RID_W-1:0] cur_rid = rr_rids[req_addr[63:61]*RID_W +: RID_W];
  wire [VPN_W-1:0] cur_vpn = req_addr[VA_BITS-1:PAGE_BITS];
  wire va_bad  = |req_addr[60:VA_BITS];
  wire pa_bad  = |req_addr[63:PA_BITS];
  wire want_rd = req_kind[0] | ~req_kind[1];
  wire want_wr = req_kind[1];
  wire [1:0] pl = req_use_imm ? req_imm : req_reg_lo;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) e_v[i] <= 1'b0;
      else if (fill_en && fill_idx == IDX_W'(i)) e_v[i] <= fill_valid;

    always_ff @(posedge clk)
      if (fill_en && fill_idx == IDX_W'(i)) begin
        e_rid[i] <= fill_rid;
        e_vpn[i] <= fill_vpn;
        e_pl[i]  <= fill_pl;
        e_ar[i]  <= fill_ar;
        e_key[i] <= fill_key;
      end

    assign match[i] = e_v[i] && e_rid[i] == cur_rid && e_vpn[i] == cur_vpn;
  end

  logic [1:0]       s_pl;
  logic [2:0]       s_ar;
  logic [KEY_W-1:0] s_key;
  always_comb begin
    s_pl = '0; s_ar = '0; s_key = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) begin
        s_pl = e_pl[i]; s_ar = e_ar[i]; s_key = e_key[i];
      end
  end

  wire hit      = |match;
  wire pl_ok    = pl >= s_pl;
  wire rd_grant = s_ar[0] && pl_ok;
  wire wr_grant = s_ar[1] && !s_ar[2] && pl_ok;
  wire rights_fail = (want_rd && !rd_grant) || (want_wr && !wr_grant);
  wire key_fail = ctl_pk && (s_key != key_cur || (want_rd && key_no_rd) || (want_wr && key_no_wr));
  wire permitted = !rights_fail && !key_fail;

  logic       n_walk, n_res;
  logic [2:0] n_flt;
  always_comb begin
    n_walk = 1'b0; n_res = 1'b0; n_flt = F_NONE;
    if (!req_fault_form) begin
      if (va_bad)      n_res = 1'b0;
      else if (hit)    n_res = permitted;
      else if (ctl_dt) n_walk = 1'b1;
      else             n_flt = ctl_ic ? F_ALT : F_NEST;
    end else if (!ctl_dt) begin
      if (pa_bad) n_flt = F_UNIMPL;
    end else begin
      if (va_bad)          n_flt = F_UNIMPL;
      else if (!hit)       n_walk = 1'b1;
      else if (!permitted) n_flt = rights_fail ? F_RIGHTS : F_KEY;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_ready  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_result <= 1'b0;
      rsp_fault  <= F_NONE;
      rsp_synd   <= 3'b000;
      walk_req   <= 1'b0;
      walk_addr  <= '0;
    end else begin
      req_ready  <= 1'b1;
      rsp_valid  <= accept && !n_walk;
      walk_req   <= accept && n_walk;
      rsp_result <= accept && n_res;
      rsp_fault  <= accept ? n_flt : F_NONE;
      rsp_synd   <= (accept && n_flt != F_NONE) ? {1'b1, want_wr, want_rd} : 3'b000;
      if (accept) walk_addr <= req_addr;
    end

  assert_one_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_valid ^ walk_req));
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!rsp_valid && !walk_req));
  assert_fault_form_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != F_NONE) |-> !rsp_result);
  assert_no_walk_untranslated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ctl_dt) |=> !walk_req);
  assert_walk_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (walk_addr == $past(req_addr)));
  assert_unimpl_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_fault_form && |req_addr[60:VA_BITS]) |=> (rsp_valid && !rsp_result && rsp_fault == F_NONE));
  assert_synd_on_fault_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != F_NONE) |-> (rsp_synd[2] && (rsp_synd[1] || rsp_synd[0])));
  assert_synd_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault == F_NONE) |-> (rsp_synd == 3'b000));

endmodule

// File: tb/tb_probe_check.sv
module tb_probe_check;
  localparam int CLK_PERIOD = 10;
  localparam int VA = 50, PA = 48, PG = 12, NE = 4, RW = 8, KW = 4;
  localparam int VW = VA - PG;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [63:0] req_addr = '0;
  logic [1:0] req_reg_lo = '0, req_imm = '0, req_kind = '0;
  logic req_use_imm = 0, req_fault_form = 0;
  logic ctl_dt = 1, ctl_pk = 0, ctl_ic = 1;
  logic [8*RW-1:0] rr_rids;
  logic [KW-1:0] key_cur = '0;
  logic key_no_rd = 0, key_no_wr = 0;
  logic fill_en = 0, fill_valid = 0;
  logic [1:0] fill_idx = '0, fill_pl = '0;
  logic [RW-1:0] fill_rid = '0;
  logic [VW-1:0] fill_vpn = '0;
  logic [2:0] fill_ar = '0;
  logic [KW-1:0] fill_key = '0;
  logic rsp_valid, rsp_result, walk_req;
  logic [2:0] rsp_fault, rsp_synd;
  logic [63:0] walk_addr;

  int checks = 0, errors = 0;
  logic sh_v [NE];
  logic [RW-1:0] sh_rid [NE];
  logic [VW-1:0] sh_vpn [NE];
  logic [1:0] sh_pl [NE];
  logic [2:0] sh_ar [NE];
  logic [KW-1:0] sh_key [NE];

  probe_check dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [63:0] mk(input int r, input int vpn, input int off);
    return {3'(r), 61'((64'(vpn) << PG) | 64'(off))};
  endfunction

  function automatic logic [7:0] model(input logic [63:0] a, input logic [1:0] pl);
    logic wr, rd, vb, pb, hit, rf, kf, walk, res;
    logic [2:0] flt;
    logic [1:0] epl; logic [2:0] ar; logic [KW-1:0] k;
    logic [RW-1:0] rid;
    rd = req_kind[0] | ~req_kind[1]; wr = req_kind[1];
    vb = a[60:VA] != 0; pb = a[63:PA] != 0;
    rid = rr_rids[a[63:61]*RW +: RW];
    hit = 0; epl = 0; ar = 0; k = 0;
    for (int i = NE - 1; i >= 0; i--)
      if (sh_v[i] && sh_rid[i] == rid && sh_vpn[i] == a[VA-1:PG]) begin
        hit = 1; epl = sh_pl[i]; ar = sh_ar[i]; k = sh_key[i];
      end
    rf = (rd && !(ar[0] && pl >= epl)) || (wr && !(ar[1] && !ar[2] && pl >= epl));
    kf = ctl_pk && (k != key_cur || (rd && key_no_rd) || (wr && key_no_wr));
    walk = 0; res = 0; flt = 0;
    if (!req_fault_form) begin
      if (vb) res = 0;
      else if (hit) res = !rf && !kf;
      else if (ctl_dt) walk = 1;
      else flt = ctl_ic ? 3'd2 : 3'd3;
    end else if (!ctl_dt) begin
      if (pb) flt = 3'd1;
    end else if (vb) flt = 3'd1;
    else if (!hit) walk = 1;
    else if (rf) flt = 3'd4;
    else if (kf) flt = 3'd5;
    return {walk, res, flt, (flt != 0) ? {1'b1, wr, rd} : 3'b000};
  endfunction

  task automatic fill(input int idx, input logic v, input int r, input int vpn,
                      input int pl, input int ar, input int key);
    @(negedge clk);
    fill_en = 1; fill_idx = 2'(idx); fill_valid = v; fill_rid = rr_rids[r*RW +: RW];
    fill_vpn = VW'(vpn); fill_pl = 2'(pl); fill_ar = 3'(ar); fill_key = KW'(key);
    sh_v[idx] = v; sh_rid[idx] = fill_rid; sh_vpn[idx] = fill_vpn;
    sh_pl[idx] = fill_pl; sh_ar[idx] = fill_ar; sh_key[idx] = fill_key;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic probe(input string tag, input logic [63:0] a, input logic [1:0] rlo,
                       input logic [1:0] imm, input logic ui, input logic [1:0] kind, input logic ff);
    logic [7:0] e;
    logic [8:0] act, exp;
    @(negedge clk);
    req_addr = a; req_reg_lo = rlo; req_imm = imm; req_use_imm = ui;
    req_kind = kind; req_fault_form = ff; req_valid = 1;
    e = model(a, ui ? imm : rlo);
    @(negedge clk);
    req_valid = 0;
    act = {walk_req, rsp_valid, rsp_result, rsp_fault, rsp_synd};
    exp = {e[7], !e[7], e[6:0]};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%b expected=%b", tag, a, act, exp);
    end
    if (e[7]) begin
      checks++;
      if (walk_addr !== a) begin
        errors++;
        $display("FAIL R8 walk_addr actual=%h expected=%h", walk_addr, a);
      end
    end
  endtask

  initial begin
    for (int r = 0; r < 8; r++) rr_rids[r*RW +: RW] = RW'(8'h30 + r);
    for (int i = 0; i < NE; i++) sh_v[i] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (req_ready !== 1 || rsp_valid !== 0 || walk_req !== 0) begin
      errors++;
      $display("FAIL R1 reset actual=%b%b%b expected=100", req_ready, rsp_valid, walk_req);
    end

    // R13 fills; R6 R2 R3 R5 full sweep on entry 0
    fill(1, 1, 5, 7, 1, 3, 2);
    fill(2, 1, 2, 9, 0, 3, 3);
    for (int ep = 0; ep < 4; ep++)
      for (int ar = 0; ar < 8; ar++) begin
        fill(0, 1, 2, 5, ep, ar, 0);
        for (int p = 0; p < 4; p++)
          for (int k = 0; k < 4; k++)
            for (int ff = 0; ff < 2; ff++)
              for (int ui = 0; ui < 2; ui++)
                probe(ff ? "R3_R6_R5" : "R2_R6_R5", mk(2, 5, 16),
                      ui ? ~2'(p) : 2'(p), ui ? 2'(p) : ~2'(p), 1'(ui), 2'(k), 1'(ff));
      end

    // R5 explicit: reg says 3, imm says 0, entry privilege 2, read-only
    fill(0, 1, 2, 5, 2, 1, 0);
    probe("R5", mk(2, 5, 0), 2'd3, 2'd0, 1'b1, 2'b01, 1'b0);
    probe("R5", mk(2, 5, 0), 2'd3, 2'd0, 1'b0, 2'b01, 1'b0);

    // R7 key sweep on entry 2
    ctl_pk = 1;
    for (int kc = 0; kc < 8; kc++)
      for (int d = 0; d < 4; d++)
        for (int k = 1; k < 4; k++)
          for (int ff = 0; ff < 2; ff++) begin
            key_cur = KW'(kc); key_no_rd = d[0]; key_no_wr = d[1];
            probe("R7", mk(2, 9, 0), 2'd3, 2'd0, 1'b0, 2'(k), 1'(ff));
          end
    ctl_pk = 0; key_cur = 4'd9; key_no_rd = 1; key_no_wr = 1;
    probe("R7", mk(2, 9, 0), 2'd3, 2'd0, 1'b0, 2'b11, 1'b0);
    probe("R7", mk(2, 9, 0), 2'd3, 2'd0, 1'b0, 2'b11, 1'b1);
    key_no_rd = 0; key_no_wr = 0;

    // R4 region selection, R8 walk
    probe("R4", mk(3, 9, 0), 2'd3, 2'd0, 1'b0, 2'b01, 1'b0);
    probe("R4", mk(5, 7, 0), 2'd3, 2'd0, 1'b0, 2'b11, 1'b0);
    probe("R8", mk(6, 100, 4), 2'd3, 2'd0, 1'b0, 2'b10, 1'b0);
    probe("R8", mk(6, 100, 4), 2'd3, 2'd0, 1'b0, 2'b10, 1'b1);

    // R9 translation off, result form
    ctl_dt = 0;
    for (int ic = 0; ic < 2; ic++) begin
      ctl_ic = 1'(ic);
      probe("R9", mk(1, 44, 0), 2'd3, 2'd0, 1'b0, 2'b01, 1'b0);
      probe("R9", mk(1, 44, 0), 2'd3, 2'd0, 1'b0, 2'b11, 1'b0);
      probe("R9", mk(2, 9, 0), 2'd3, 2'd0, 1'b0, 2'b11, 1'b0);
    end
    // R10 physical bypass, R11 physical range
    probe("R10", mk(0, 44, 0), 2'd0, 2'd0, 1'b0, 2'b11, 1'b1);
    probe("R10", mk(0, 5, 0), 2'd0, 2'd0, 1'b0, 2'b10, 1'b1);
    probe("R11", 64'h0001_0000_0000_0000, 2'd0, 2'd0, 1'b0, 2'b10, 1'b1);
    probe("R11", mk(2, 5, 0), 2'd0, 2'd0, 1'b0, 2'b01, 1'b1);
    probe("R11", 64'h0080_0000_0000_0000, 2'd0, 2'd0, 1'b0, 2'b01, 1'b0);

    // R11 virtual range with translation on
    ctl_dt = 1; ctl_ic = 1;
    probe("R11", mk(2, 0, 0) | 64'h0080_0000_0000_0000, 2'd3, 2'd0, 1'b0, 2'b01, 1'b0);
    probe("R11", mk(2, 0, 0) | 64'h0080_0000_0000_0000, 2'd3, 2'd0, 1'b0, 2'b11, 1'b1);
    probe("R12", 64'h0004_0000_0000_0000, 2'd3, 2'd0, 1'b0, 2'b10, 1'b1);
    probe("R11", 64'h0002_0000_0000_0000, 2'd3, 2'd0, 1'b0, 2'b11, 1'b0);

    // R13 invalidate
    fill(2, 0, 2, 9, 0, 3, 3);
    probe("R13", mk(2, 9, 0), 2'd3, 2'd0, 1'b0, 2'b01, 1'b0);

    // R1 idle cycles give no event
    @(negedge clk); @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || walk_req !== 0) begin
      errors++;
      $display("FAIL R1 idle actual=%b%b expected=00", rsp_valid, walk_req);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule